// File: doc/BRIEF.md
# UART Line Status and Interrupt Control

This block keeps the line-status flags of one serial channel that do not belong to the shifters: a sticky receive-error flag, a transmitter-idle flag and a holding-register-empty flag. It also holds the interrupt enable register and the modem-control byte. It combines five interrupt sources with their enables into one request line, marks whether the active request belongs to the top priority level, drives the output-enable of the interrupt pin, and raises a request to gate the channel clock for sleep.

The receive path reports each character moved into the receive holding register. The report is a one-cycle push strobe together with parity, framing, break and ninth-bit (address) flags. The transmit path reports its two empty levels. The modem block reports a level that stays high while a modem-status change is pending. Software reaches three byte registers through a simple strobe port. A mode selector and a 9-bit framing input change how the error flag, enable bit 5 and the address bit behave.

Top module: `uart_sic_top`

## Requirements
- R1: LSR (reg_addr 1) bit 6 reads 1 only while thr_empty and tsr_empty are both 1. LSR bit 5 reads thr_empty. LSR bits 4..0 read 0.
- R2: A cycle with rx_push=1 and any of rx_frm_err, rx_brk or rx_par_err set makes the error flag 1 from the next clock edge. Outside the 450 mode, LSR bit 7 shows that flag.
- R3: A read strobe with reg_addr 1 returns the flag's current value in the same cycle and clears it at the closing edge of that cycle. If an error push arrives in the same cycle as the read, the flag stays 1.
- R4: With mode_sel 0 (450 mode), LSR bit 7 reads 0 whatever the flag holds.
- R5: With nine_bit_en=1, rx_par_err has no effect on the error flag. Framing and break still set it.
- R6: IER (reg_addr 0) is written on reg_wr. Bits 5..0 hold the written value and bits 7..6 read 0. MCR (reg_addr 2) holds all 8 written bits. reg_addr 3 reads 0.
- R7: irq is the OR of five products: rx_avail AND IER bit 0; thr_empty AND IER bit 1; error flag AND IER bit 2; address flag AND IER bit 2 AND nine_bit_en; msr_delta AND IER bit 3. Each term stays high while its source stays high.
- R8: With nine_bit_en=1, a push with rx_addr_bit=1 sets an address flag. An LSR read clears the flag, with the same same-cycle rule as R3. irq_lvl1 is high while either the error term or the address term of R7 is active.
- R9: irq_oe is 1 when int_sel=1. When int_sel=0, irq_oe equals MCR bit 3.
- R10: sleep_req is IER bit 4, ORed with IER bit 5 when mode_sel is 3 (750 mode) and nine_bit_en=0.
- R11: A synchronous reset clears the error flag, the address flag, IER and MCR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Compatibility mode: 0=450, 1=550, 2=650, 3=750 |
| nine_bit_en | input | 1 | 9-bit framing enabled |
| rx_push | input | 1 | Character moved into receive holding register |
| rx_par_err | input | 1 | Parity error on pushed character |
| rx_frm_err | input | 1 | Framing error on pushed character |
| rx_brk | input | 1 | Break on pushed character |
| rx_addr_bit | input | 1 | Ninth bit of pushed character |
| rx_avail | input | 1 | Receive data available level |
| thr_empty | input | 1 | Transmit holding register empty |
| tsr_empty | input | 1 | Transmit shift register empty |
| msr_delta | input | 1 | Modem-status change pending |
| int_sel | input | 1 | Interrupt pin drive select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 IER, 1 LSR, 2 MCR |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of selected register |
| irq | output | 1 | Combined interrupt request |
| irq_lvl1 | output | 1 | Active request is of top level |
| irq_oe | output | 1 | Interrupt pin output enable |
| sleep_req | output | 1 | Clock gating request |

## Verification
Error pushes are tried one flag at a time, under each mode and with 9-bit framing on and off. These cases separate the masking of bit 7 in 450 mode from the parity suppression in 9-bit mode. A push that coincides with an LSR read separates set-priority from clear-priority. Each interrupt source is raised with its enable on and then off, to catch a term wired to the wrong enable bit. A pseudo-random run over all inputs exercises the combined request against the reference on every clock. The sleep and pin-drive cases sweep IER bits 4 and 5 across the modes, and int_sel against MCR bit 3.

// File: rtl/uart_sic_pkg.sv
package uart_sic_pkg;

    localparam int SRC_RDA  = 0;
    localparam int SRC_THRE = 1;
    localparam int SRC_RLS  = 2;
    localparam int SRC_ADDR = 3;
    localparam int SRC_MS   = 4;
    localparam int NSRC     = 5;

    localparam int IER_USED = 6;

    typedef enum logic [1:0] {
        MODE_450 = 2'd0,
        MODE_550 = 2'd1,
        MODE_650 = 2'd2,
        MODE_750 = 2'd3
    } compat_e;

    typedef enum logic [1:0] {
        RA_IER  = 2'd0,
        RA_LSR  = 2'd1,
        RA_MCR  = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic push;
        logic par;
        logic frm;
        logic brk;
        logic addr;
    } rx_evt_t;

    function automatic logic err_cause(rx_evt_t e, logic nine);
        return e.push && (e.brk || e.frm || (e.par && !nine));
    endfunction

    function automatic logic sleep_on(logic en4, logic en5, compat_e m, logic nine);
        return en4 || (en5 && (m == MODE_750) && !nine);
    endfunction

endpackage

// File: rtl/uart_sic_flags.sv
module uart_sic_flags
    import uart_sic_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  rx_evt_t evt,
    input  logic    nine,
    input  logic    rd_clr,
    output logic    err_q,
    output logic    addr_q
);
    logic err_set;
    logic addr_set;

    assign err_set  = err_cause(evt, nine);
    assign addr_set = evt.push && evt.addr && nine;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q  <= 1'b0;
            addr_q <= 1'b0;
        end else begin
            if (err_set)     err_q <= 1'b1;
            else if (rd_clr) err_q <= 1'b0;
            if (addr_set)    addr_q <= 1'b1;
            else if (rd_clr) addr_q <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_sic_regs.sv
module uart_sic_regs
    import uart_sic_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  reg_addr_e        addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ier_q,
    output logic [REG_W-1:0] mcr_q
);
    localparam logic [REG_W-1:0] IER_MASK = REG_W'((1 << IER_USED) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ier_q <= '0;
            mcr_q <= '0;
        end else if (wr) begin
            case (addr)
                RA_IER:  ier_q <= wdata & IER_MASK;
                RA_MCR:  mcr_q <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/uart_sic_irq.sv
module uart_sic_irq
    import uart_sic_pkg::*;
(
    input  logic [NSRC-1:0] src,
    input  logic [NSRC-1:0] en,
    output logic            irq,
    output logic            lvl1
);
    logic [NSRC-1:0] act;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign act[i] = src[i] & en[i];
    end

    assign irq  = |act;
    assign lvl1 = act[SRC_RLS] | act[SRC_ADDR];
endmodule

// File: rtl/uart_sic_top.sv
module uart_sic_top
    import uart_sic_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic             nine_bit_en,
    input  logic             rx_push,
    input  logic             rx_par_err,
    input  logic             rx_frm_err,
    input  logic             rx_brk,
    input  logic             rx_addr_bit,
    input  logic             rx_avail,
    input  logic             thr_empty,
    input  logic             tsr_empty,
    input  logic             msr_delta,
    input  logic             int_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq,
    output logic             irq_lvl1,
    output logic             irq_oe,
    output logic             sleep_req
);
    localparam int LSR_ERR  = 7;
    localparam int LSR_TEMT = 6;
    localparam int LSR_THRE = 5;
    localparam int MCR_OE   = 3;

    compat_e         mode;
    reg_addr_e       ra;
    rx_evt_t         evt;
    logic            err_flag;
    logic            addr_flag;
    logic            lsr_rd;
    logic [REG_W-1:0] ier_bits;
    logic [REG_W-1:0] mcr_bits;
    logic [REG_W-1:0] lsr_val;
    logic [NSRC-1:0] src;
    logic [NSRC-1:0] en;

    assign mode   = compat_e'(mode_sel);
    assign ra     = reg_addr_e'(reg_addr);
    assign evt    = '{push: rx_push, par: rx_par_err, frm: rx_frm_err,
                      brk: rx_brk, addr: rx_addr_bit};
    assign lsr_rd = reg_rd && (ra == RA_LSR);

    uart_sic_flags u_flags (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .nine   (nine_bit_en),
        .rd_clr (lsr_rd),
        .err_q  (err_flag),
        .addr_q (addr_flag)
    );

    uart_sic_regs #(.REG_W(REG_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .addr  (ra),
        .wdata (reg_wdata),
        .ier_q (ier_bits),
        .mcr_q (mcr_bits)
    );

    assign src[SRC_RDA]  = rx_avail;
    assign src[SRC_THRE] = thr_empty;
    assign src[SRC_RLS]  = err_flag;
    assign src[SRC_ADDR] = addr_flag;
    assign src[SRC_MS]   = msr_delta;

    assign en[SRC_RDA]   = ier_bits[0];
    assign en[SRC_THRE]  = ier_bits[1];
    assign en[SRC_RLS]   = ier_bits[2];
    assign en[SRC_ADDR]  = ier_bits[2] & nine_bit_en;
    assign en[SRC_MS]    = ier_bits[3];

    uart_sic_irq u_irq (
        .src  (src),
        .en   (en),
        .irq  (irq),
        .lvl1 (irq_lvl1)
    );

    always_comb begin
        lsr_val           = '0;
        lsr_val[LSR_ERR]  = err_flag && (mode != MODE_450);
        lsr_val[LSR_TEMT] = thr_empty && tsr_empty;
        lsr_val[LSR_THRE] = thr_empty;
    end

    always_comb begin
        case (ra)
            RA_IER:  reg_rdata = ier_bits;
            RA_LSR:  reg_rdata = lsr_val;
            RA_MCR:  reg_rdata = mcr_bits;
            default: reg_rdata = '0;
        endcase
    end

    assign irq_oe    = int_sel || mcr_bits[MCR_OE];
    assign sleep_req = sleep_on(ier_bits[4], ier_bits[5], mode, nine_bit_en);
endmodule

// File: rtl/uart_sic_chk.sv
module uart_sic_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_sel,
    input logic       nine_bit_en,
    input logic       rx_push,
    input logic       rx_par_err,
    input logic       rx_frm_err,
    input logic       rx_brk,
    input logic       rx_avail,
    input logic       tsr_empty,
    input logic       reg_rd,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_rdata,
    input logic       int_sel,
    input logic       irq,
    input logic       irq_oe,
    input logic       err_q,
    input logic [7:0] ier_q
);
    logic hard_err;
    assign hard_err = rx_push && (rx_frm_err || rx_brk);

    a_r2_err_sets: assert property (@(posedge clk) disable iff (rst)
        hard_err |=> err_q);

    a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 2'd1 && !rx_push) |=> !err_q);

    a_r5_parity_ignored: assert property (@(posedge clk) disable iff (rst)
        (nine_bit_en && !err_q && !hard_err) |=> !err_q);

    a_r1_temt_low: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd1 && !tsr_empty) |-> !reg_rdata[6]);

    a_r7_rda_raises: assert property (@(posedge clk) disable iff (rst)
        (rx_avail && ier_q[0]) |-> irq);

    a_r9_sel_drives: assert property (@(posedge clk) disable iff (rst)
        int_sel |-> irq_oe);

    always_comb begin
        if (!rst && mode_sel == 2'd0 && reg_addr == 2'd1)
            a_r4_legacy_zero: assert (!reg_rdata[7]);
    end

    logic unused_ok;
    assign unused_ok = rx_par_err;
endmodule

bind uart_sic_top uart_sic_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_sel    (mode_sel),
    .nine_bit_en (nine_bit_en),
    .rx_push     (rx_push),
    .rx_par_err  (rx_par_err),
    .rx_frm_err  (rx_frm_err),
    .rx_brk      (rx_brk),
    .rx_avail    (rx_avail),
    .tsr_empty   (tsr_empty),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .int_sel     (int_sel),
    .irq         (irq),
    .irq_oe      (irq_oe),
    .err_q       (err_flag),
    .ier_q       (ier_bits)
);

// File: tb/uart_sic_top_tb.sv
`timescale 1ns/1ps
module uart_sic_top_tb;
    logic clk = 0;
    logic rst = 1;
    logic [1:0] mode_sel = 2'd1;
    logic nine_bit_en = 0, rx_push = 0, rx_par_err = 0, rx_frm_err = 0, rx_brk = 0;
    logic rx_addr_bit = 0, rx_avail = 0, thr_empty = 0, tsr_empty = 0, msr_delta = 0;
    logic int_sel = 0, reg_wr = 0, reg_rd = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic irq, irq_lvl1, irq_oe, sleep_req;

    always #4 clk = ~clk;

    uart_sic_top u_dut (.*);

    int total = 0, bad = 0;
    bit done = 0;
    string cur_req = "R11";

    // reference state
    bit m_err = 0, m_addr = 0;
    bit [7:0] m_ier = 0, m_mcr = 0;

    task automatic check(string what, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got=%h exp=%h at %0t", cur_req, what, got, exp, $time);
        end
    endtask

    task automatic compare();
        bit [7:0] e_rd;
        bit e_irq, e_l1, e_oe, e_sl;
        case (reg_addr)
            2'd0: e_rd = m_ier;
            2'd1: e_rd = {(mode_sel != 0) && m_err, thr_empty && tsr_empty, thr_empty, 5'b0};
            2'd2: e_rd = m_mcr;
            default: e_rd = 0;
        endcase
        e_l1  = (m_err && m_ier[2]) || (m_addr && m_ier[2] && nine_bit_en);
        e_irq = (rx_avail && m_ier[0]) || (thr_empty && m_ier[1]) || e_l1
                || (msr_delta && m_ier[3]);
        e_oe  = int_sel || m_mcr[3];
        e_sl  = m_ier[4] || (m_ier[5] && mode_sel == 3 && !nine_bit_en);
        check("reg_rdata", reg_rdata, e_rd);
        check("irq", {7'b0, irq}, {7'b0, e_irq});
        check("irq_lvl1", {7'b0, irq_lvl1}, {7'b0, e_l1});
        check("irq_oe", {7'b0, irq_oe}, {7'b0, e_oe});
        check("sleep_req", {7'b0, sleep_req}, {7'b0, e_sl});
    endtask

    task automatic model_step();
        bit es, as, rc;
        es = rx_push && (rx_brk || rx_frm_err || (rx_par_err && !nine_bit_en));
        as = rx_push && rx_addr_bit && nine_bit_en;
        rc = reg_rd && reg_addr == 2'd1;
        if (rst) begin
            m_err = 0; m_addr = 0; m_ier = 0; m_mcr = 0;
        end else begin
            m_err  = es ? 1'b1 : (rc ? 1'b0 : m_err);
            m_addr = as ? 1'b1 : (rc ? 1'b0 : m_addr);
            if (reg_wr && reg_addr == 2'd0) m_ier = reg_wdata & 8'h3f;
            if (reg_wr && reg_addr == 2'd2) m_mcr = reg_wdata;
        end
    endtask

    task automatic cyc();
        #2;
        compare();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle();
        rx_push = 0; rx_par_err = 0; rx_frm_err = 0; rx_brk = 0; rx_addr_bit = 0;
        reg_wr = 0; reg_rd = 0;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1; cyc(); idle();
    endtask

    task automatic rd(logic [1:0] a);
        reg_addr = a; reg_rd = 1; cyc(); idle();
    endtask

    task automatic push(bit p, bit f, bit b, bit ad);
        rx_push = 1; rx_par_err = p; rx_frm_err = f; rx_brk = b; rx_addr_bit = ad;
        cyc(); idle();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit [15:0] lf;
        @(posedge clk); @(posedge clk); @(negedge clk);
        // R11: reset state
        cur_req = "R11"; reg_addr = 0; cyc();
        rst = 1; reg_addr = 2; cyc();
        rst = 0;

        // R6: register widths
        cur_req = "R6";
        wr(0, 8'hff); rd(0);
        wr(2, 8'ha5); rd(2);
        reg_addr = 3; cyc();
        wr(0, 8'h00); wr(2, 8'h00);

        // R1: transmitter idle combos
        cur_req = "R1";
        reg_addr = 1;
        for (int i = 0; i < 4; i++) begin
            thr_empty = i[0]; tsr_empty = i[1]; cyc();
        end

        // R2/R3: error set and read-clear
        mode_sel = 2'd1;
        cur_req = "R2"; push(0, 1, 0, 0); reg_addr = 1; cyc();
        cur_req = "R3"; rd(1); reg_addr = 1; cyc();
        cur_req = "R2"; push(0, 0, 1, 0); rd(1); push(1, 0, 0, 0); reg_addr = 1; cyc();
        cur_req = "R3";
        reg_addr = 1; reg_rd = 1; rx_push = 1; rx_frm_err = 1; cyc(); idle();
        reg_addr = 1; cyc();
        rd(1); reg_addr = 1; cyc();

        // R4: legacy mode hides the flag
        cur_req = "R4"; mode_sel = 2'd0;
        push(0, 1, 0, 0); reg_addr = 1; cyc();
        wr(0, 8'h04); reg_addr = 1; cyc();
        mode_sel = 2'd2; cyc();
        rd(1); wr(0, 8'h00);

        // R5: 9-bit suppresses parity
        cur_req = "R5"; nine_bit_en = 1;
        push(1, 0, 0, 0); reg_addr = 1; cyc();
        push(1, 1, 0, 0); reg_addr = 1; cyc();
        rd(1);

        // R7: each source with and without its enable
        cur_req = "R7"; nine_bit_en = 0; thr_empty = 0; tsr_empty = 0;
        rx_avail = 1; cyc(); wr(0, 8'h01); cyc(); rx_avail = 0; cyc();
        thr_empty = 1; cyc(); wr(0, 8'h02); cyc(); thr_empty = 0; cyc();
        msr_delta = 1; cyc(); wr(0, 8'h08); cyc(); msr_delta = 0; cyc();
        wr(0, 8'h04); push(0, 1, 0, 0); cyc(); rd(1); cyc();

        // R8: address-bit interrupt
        cur_req = "R8"; nine_bit_en = 1;
        push(0, 0, 0, 1); cyc(); cyc();
        reg_addr = 1; reg_rd = 1; rx_push = 1; rx_addr_bit = 1; cyc(); idle();
        cyc(); rd(1); cyc();
        nine_bit_en = 0; push(0, 0, 0, 1); cyc();
        nine_bit_en = 1; cyc();
        wr(0, 8'h00);

        // R9: pin drive
        cur_req = "R9";
        int_sel = 1; cyc(); int_sel = 0; cyc();
        wr(2, 8'h08); cyc(); int_sel = 1; cyc(); int_sel = 0; wr(2, 8'h00); cyc();

        // R10: sleep request
        cur_req = "R10";
        for (int m = 0; m < 4; m++) begin
            mode_sel = m[1:0];
            for (int n = 0; n < 2; n++) begin
                nine_bit_en = n[0];
                wr(0, 8'h20); cyc(); wr(0, 8'h10); cyc();
            end
        end
        wr(0, 8'h00);

        // R7: pseudo-random sweep against the reference
        cur_req = "R7";
        lf = 16'hace1;
        for (int k = 0; k < 400; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            mode_sel = lf[1:0]; nine_bit_en = lf[2]; rx_push = lf[3];
            rx_par_err = lf[4]; rx_frm_err = lf[5] & lf[6]; rx_brk = lf[7] & lf[8];
            rx_addr_bit = lf[9]; rx_avail = lf[10]; thr_empty = lf[11];
            tsr_empty = lf[12]; msr_delta = lf[13]; int_sel = lf[14];
            reg_addr = lf[1:0] ^ lf[9:8]; reg_rd = lf[15];
            reg_wr = (lf[7:5] == 3'b101); reg_wdata = lf[15:8];
            cyc();
        end
        idle();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule